// File: doc/BRIEF.md
# Sinc3 Decimator with Phase Trim

This block turns two single-bit delta-sigma bitstreams, one from a voltage modulator and one from a current modulator, into signed 24-bit words. Each stream goes through a third-order cascaded integrator-comb filter that reduces the rate by 128. Both channels share one phase counter, so their words come out together under a single one-cycle strobe. A modulator sample is accepted on each clock in which `smp_en` is high. In the intended system that happens once every eight master clocks, which gives one output word per 1024 master clocks.

Fine alignment between the two channels is set with a signed 8-bit trim value. The voltage stream always passes through a fixed delay of 128 modulator samples. The current stream passes through a delay of 128 minus the trim, taken from a 256-deep single-bit line. The current channel's effective sampling instant can therefore move from one output period earlier to 127/128 of a period later, in steps of one modulator sample, before any filtering happens. A new trim value is taken at an output boundary. The words that follow are flagged as not settled until the filter memory holds only samples taken with the new alignment.

Top module: `sinc3_phase_decimator`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first strobe, `v_word` and `i_word` are 0 and `word_vld` and `word_settled` are 0. Reset also empties both delay lines, and an emptied slot is read as a 0 bit.
- R2: A 1 bit enters the filter as +1 and a 0 bit as -1. Output words are 24-bit two's complement, sign-extended from the filter result. Once settled, a constant 1 stream gives +2097152, a constant 0 stream gives -2097152, and an alternating stream gives 0.
- R3: Accepted samples are numbered from 0 after reset. `word_vld` is high for exactly one cycle: the cycle after sample 127, 255, 383 and so on is accepted. It is never high at any other time.
- R4: At the strobe that follows sample n, `v_word` equals the sum over k = 0..381 of h[k]·u_v[n-3-k]. Here h[k] counts the triples (a,b,c) in 0..127 with a+b+c = k. u_v[j] is the mapped voltage bit of sample j-128 (-1 when j-128 < 0), and terms with n-3-k < 0 are 0.
- R5: `i_word` uses the same filter on u_i[j], the mapped current bit of sample j-128+P, where P is the applied trim read as signed -128..127 (-1 when that index is negative). With identical streams and P = 0, the two words are equal.
- R6: `phase_trim` is sampled only in the cycle that accepts sample 128m+127. The sampled value applies to every later sample, and values presented at any other time have no effect. After reset the applied trim is 0.
- R7: `word_settled` is 0 on the first three strobes after reset. It is also 0 on the three strobes that follow a boundary where the sampled trim differed from the applied one. It is 1 on all other strobes, and it changes only together with a strobe.
- R8: A cycle with `smp_en` low is ignored. Words, flag and filter state stay unchanged, no strobe is produced, and the bits presented in that cycle never reach any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_en | input | 1 | Accept one modulator sample from both streams this cycle |
| v_bit | input | 1 | Voltage modulator bit |
| i_bit | input | 1 | Current modulator bit |
| phase_trim | input | 8 | Signed current-channel delay trim in modulator samples |
| v_word | output | 24 | Decimated voltage word |
| i_word | output | 24 | Decimated current word |
| word_vld | output | 1 | One-cycle strobe marking both words |
| word_settled | output | 1 | Words hold only samples taken under the applied trim |

## Verification
The hardest behaviour to reach from the ports is how a trim change interacts with the output period. That covers values presented between boundaries, jumps to the extremes -128 and +127 (which reach the first and last slot of the current delay line), and the three-word settling window that each accepted change restarts. The bench changes `phase_trim` in the middle of output periods and drives identical streams into both channels, so that any misplaced delay tap shows up as a word mismatch. Random idle gaps on `smp_en` and random trim changes under random data are mixed in. A reset in the middle of a period checks that delay lines, counter and settle state all start over.

// File: rtl/s3d_pkg.sv
package s3d_pkg;
  // number of integrator and comb sections
  localparam int STAGES      = 3;
  // words flagged unsettled after reset or a trim change
  localparam int SETTLE_OUTS = 3;
  localparam int STW         = 2;

  // accumulator width: log2(DEC^3) bits of gain plus sign and headroom for +full scale
  function automatic int acc_width(input int cw);
    return STAGES * cw + 2;
  endfunction
endpackage

// File: rtl/s3d_bit_delay.sv
module s3d_bit_delay #(
  parameter int DEPTH = 128,
  parameter int TW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          din,
  input  logic [TW-1:0] tap,
  output logic          dout
);
  logic [DEPTH-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (en) sr_d = {sr_q[DEPTH-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  // slot k holds the sample accepted k+1 enables ago
  assign dout = sr_q[tap];

  a_r8_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(sr_q));
endmodule

// File: rtl/s3d_integrator.sv
module s3d_integrator
  import s3d_pkg::*;
#(
  parameter int AW = 23
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          bit_in,
  output logic [AW-1:0] acc_out
);
  logic [STAGES-1:0][AW-1:0] st_q, st_d;
  logic [AW-1:0]             step;

  always_comb begin
    step = bit_in ? AW'(1) : {AW{1'b1}};
    st_d = st_q;
    if (en) begin
      st_d[0] = st_q[0] + step;
      for (int s = 1; s < STAGES; s++) st_d[s] = st_q[s] + st_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign acc_out = st_q[STAGES-1];

  a_r8_integrators_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(st_q));
endmodule

// File: rtl/s3d_comb.sv
module s3d_comb
  import s3d_pkg::*;
#(
  parameter int DEC = 128,
  parameter int AW  = 23,
  parameter int OW  = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [AW-1:0] acc_in,
  output logic [OW-1:0] y_out
);
  localparam int FS = DEC * DEC * DEC;

  logic [STAGES-1:0][AW-1:0] dly_q, dly_d;
  logic [OW-1:0]             y_q, y_d;
  logic [AW-1:0]             run;

  always_comb begin
    dly_d = dly_q;
    y_d   = y_q;
    run   = acc_in;
    for (int s = 0; s < STAGES; s++) begin
      if (fire) dly_d[s] = run;
      run = run - dly_q[s];
    end
    if (fire) y_d = {{(OW-AW){run[AW-1]}}, run};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= '0;
      y_q   <= '0;
    end else begin
      dly_q <= dly_d;
      y_q   <= y_d;
    end
  end

  assign y_out = y_q;

  a_r2_word_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (($signed(y_out) <= FS) && ($signed(y_out) >= -FS)));
endmodule

// File: rtl/sinc3_phase_decimator.sv
module sinc3_phase_decimator
  import s3d_pkg::*;
#(
  parameter int DEC = 128,
  parameter int OW  = 24,
  parameter int PW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_en,
  input  logic          v_bit,
  input  logic          i_bit,
  input  logic [PW-1:0] phase_trim,
  output logic [OW-1:0] v_word,
  output logic [OW-1:0] i_word,
  output logic          word_vld,
  output logic          word_settled
);
  localparam int CW  = $clog2(DEC);
  localparam int AW  = acc_width(CW);
  localparam int LTW = CW + 1;
  localparam int NCH = 2;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  // shared phase counter, trim register and settle tracking
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [PW-1:0]  pc_q, pc_d;
  logic [STW-1:0] sc_q, sc_d;
  logic           set_q, set_d;
  logic           vld_q, vld_d;
  logic           boundary, pc_change;

  always_comb begin
    boundary  = smp_en && (cnt_q == CW'(DEC-1));
    pc_change = boundary && (phase_trim != pc_q);
    cnt_d     = smp_en ? cnt_q + CW'(1) : cnt_q;
    pc_d      = boundary ? phase_trim : pc_q;
    vld_d     = boundary;
    sc_d      = sc_q;
    set_d     = set_q;
    if (boundary) begin
      set_d = (sc_q == STW'(SETTLE_OUTS));
      if (pc_change)                        sc_d = '0;
      else if (sc_q != STW'(SETTLE_OUTS))   sc_d = sc_q + STW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cnt_q <= '0;
      pc_q  <= '0;
      sc_q  <= '0;
      set_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pc_q  <= pc_d;
      sc_q  <= sc_d;
      set_q <= set_d;
      vld_q <= vld_d;
    end
  end

  // delay lines: voltage fixed at DEC samples, current at DEC - trim samples
  logic [LTW-1:0] cur_tap;
  logic [NCH-1:0] dl_bit;

  assign cur_tap = LTW'(DEC-1) - LTW'(pc_q);

  s3d_bit_delay #(.DEPTH(DEC)) u_vdly (
    .clk  (clk),
    .rst_n(rst_sn),
    .en   (smp_en),
    .din  (v_bit),
    .tap  (CW'(DEC-1)),
    .dout (dl_bit[0])
  );

  s3d_bit_delay #(.DEPTH(2*DEC)) u_idly (
    .clk  (clk),
    .rst_n(rst_sn),
    .en   (smp_en),
    .din  (i_bit),
    .tap  (cur_tap),
    .dout (dl_bit[1])
  );

  // one integrator/comb pair per channel
  logic [NCH-1:0][OW-1:0] words;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [AW-1:0] acc;

    s3d_integrator #(.AW(AW)) u_int (
      .clk    (clk),
      .rst_n  (rst_sn),
      .en     (smp_en),
      .bit_in (dl_bit[c]),
      .acc_out(acc)
    );

    s3d_comb #(.DEC(DEC), .AW(AW), .OW(OW)) u_comb (
      .clk   (clk),
      .rst_n (rst_sn),
      .fire  (boundary),
      .acc_in(acc),
      .y_out (words[c])
    );
  end

  assign v_word       = words[0];
  assign i_word       = words[1];
  assign word_vld     = vld_q;
  assign word_settled = set_q;

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_sn)
    word_vld |=> !word_vld);

  a_r6_trim_hold: assert property (@(posedge clk) disable iff (!rst_sn)
    !boundary |=> $stable(pc_q));

  a_r7_flag_hold: assert property (@(posedge clk) disable iff (!rst_sn)
    !word_vld |-> $stable(word_settled));

  a_r8_words_hold: assert property (@(posedge clk) disable iff (!rst_sn)
    !word_vld |-> ($stable(v_word) && $stable(i_word)));
endmodule

// File: tb/sinc3_phase_decimator_bench.sv
module sinc3_phase_decimator_bench;
  localparam int DEC   = 128;
  localparam int OW    = 24;
  localparam int PW    = 8;
  localparam int KLEN  = 3*DEC - 2;
  localparam int FS    = DEC*DEC*DEC;
  localparam int MAXEV = 65536;

  logic          clk, rst_n, smp_en, v_bit, i_bit;
  logic [PW-1:0] phase_trim;
  logic [OW-1:0] v_word, i_word;
  logic          word_vld, word_settled;

  sinc3_phase_decimator u_sinc3_phase_decimator (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .v_bit(v_bit), .i_bit(i_bit),
    .phase_trim(phase_trim), .v_word(v_word), .i_word(i_word),
    .word_vld(word_vld), .word_settled(word_settled)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int nchk, nfail;
  bit done;
  int kern [KLEN];
  int uv [MAXEV];
  int ui [MAXEV];
  bit xv [MAXEV];
  bit xi [MAXEV];
  int ev, pc_eff, sc;
  bit exp_vld, exp_set;
  int exp_v, exp_i;
  logic [OW-1:0] last_v, last_i;

  function automatic int tri_kernel(input int k);
    int n = 0;
    for (int a = 0; a < DEC; a++) begin
      int r = k - a;
      int lo = (r - (DEC-1) > 0) ? r - (DEC-1) : 0;
      int hi = (r < DEC-1) ? r : DEC-1;
      if (hi >= lo) n += hi - lo + 1;
    end
    return n;
  endfunction

  function automatic int ref_out(input bit cur, input int n);
    int s = 0;
    for (int k = 0; k < KLEN; k++) begin
      int j = n - 3 - k;
      if (j >= 0) s += kern[k] * (cur ? ui[j] : uv[j]);
    end
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic model_event(input bit vb, input bit ib);
    int di = DEC - pc_eff;
    int np;
    uv[ev] = (ev - DEC >= 0) ? (xv[ev-DEC] ? 1 : -1) : -1;
    ui[ev] = (ev - di  >= 0) ? (xi[ev-di]  ? 1 : -1) : -1;
    xv[ev] = vb;
    xi[ev] = ib;
    if (ev % DEC == DEC-1) begin
      exp_vld = 1'b1;
      exp_v   = ref_out(1'b0, ev);
      exp_i   = ref_out(1'b1, ev);
      exp_set = (sc == 3);
      np = int'($signed(phase_trim));
      if (np != pc_eff) sc = 0;
      else if (sc < 3) sc++;
      pc_eff = np;
    end
    ev++;
  endtask

  task automatic check_outputs();
    if (exp_vld || word_vld)
      check(word_vld === exp_vld, "R3 strobe", int'(word_vld), int'(exp_vld));
    if (exp_vld && word_vld) begin
      check(int'($signed(v_word)) == exp_v, "R4 voltage word", int'($signed(v_word)), exp_v);
      check(int'($signed(i_word)) == exp_i, "R5/R6 current word", int'($signed(i_word)), exp_i);
      check(word_settled === exp_set, "R7 settled flag", int'(word_settled), int'(exp_set));
      last_v = v_word;
      last_i = i_word;
    end else if (!word_vld) begin
      check((v_word === last_v) && (i_word === last_i), "R8 words held",
            int'($signed(v_word)), int'($signed(last_v)));
    end
    exp_vld = 1'b0;
  endtask

  task automatic tick(input bit en, input bit vb, input bit ib);
    smp_en = en;
    v_bit  = vb;
    i_bit  = ib;
    if (en) model_event(vb, ib);
    @(negedge clk);
    check_outputs();
  endtask

  task automatic check_reset_state(input string tag);
    check(v_word === '0 && i_word === '0, tag, int'($signed(v_word)), 0);
    check(word_vld === 1'b0 && word_settled === 1'b0, tag, int'(word_vld) + int'(word_settled), 0);
  endtask

  task automatic do_reset();
    smp_en = 1'b0;
    rst_n  = 1'b0;
    repeat (3) @(negedge clk);
    check_reset_state("R1 reset held");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_reset_state("R1 after release");
    ev = 0; pc_eff = 0; sc = 0; exp_vld = 1'b0;
    last_v = '0; last_i = '0;
  endtask

  // mode: 0 ones, 1 zeros, 2 alternating, 3 random identical, 4 random independent
  task automatic run(input int nsmp, input int mode, input int gapmax, input bit trim_walk);
    for (int s = 0; s < nsmp; s++) begin
      bit vb, ib;
      int gaps = $urandom_range(gapmax, 0);
      for (int g = 0; g < gaps; g++) tick(1'b0, 1'($urandom), 1'($urandom));
      case (mode)
        0: begin vb = 1'b1; ib = 1'b1; end
        1: begin vb = 1'b0; ib = 1'b0; end
        2: begin vb = ev[0]; ib = ev[0]; end
        3: begin vb = 1'($urandom); ib = vb; end
        default: begin vb = 1'($urandom); ib = 1'($urandom); end
      endcase
      if (trim_walk && ($urandom_range(199, 0) == 0)) phase_trim = PW'($urandom);
      tick(1'b1, vb, ib);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nfail++;
      $display("FAIL R3 watchdog: actual %0d cycles expected fewer", 200000);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    nchk = 0; nfail = 0; done = 1'b0;
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < KLEN; k++) kern[k] = tri_kernel(k);
    rst_n = 1'b0; smp_en = 1'b0; v_bit = 1'b0; i_bit = 1'b0; phase_trim = '0;
    @(negedge clk);
    do_reset();

    // R2: full-scale constants and alternating input
    run(6*DEC, 0, 0, 1'b0);
    check(int'($signed(last_v)) == FS, "R2 ones full scale", int'($signed(last_v)), FS);
    run(6*DEC, 1, 1, 1'b0);
    check(int'($signed(last_v)) == -FS, "R2 zeros full scale", int'($signed(last_v)), -FS);
    run(6*DEC, 2, 2, 1'b0);
    check(int'($signed(last_v)) == 0, "R2 alternating", int'($signed(last_v)), 0);

    // R5: identical streams with zero trim give identical words
    run(5*DEC, 3, 2, 1'b0);
    check(last_v === last_i, "R5 zero trim match", int'($signed(last_i)), int'($signed(last_v)));

    // R6: trim changes presented mid-period, including both extremes
    run(DEC/2, 3, 1, 1'b0);
    phase_trim = 8'd37;
    run(6*DEC, 3, 1, 1'b0);
    phase_trim = 8'h80;
    run(6*DEC + 17, 3, 2, 1'b0);
    phase_trim = 8'h7f;
    run(6*DEC, 4, 2, 1'b0);

    // random data, idle gaps and random trim walk
    run(60*DEC, 4, 3, 1'b1);

    // R1: reset in the middle of a period, trim held nonzero
    run(DEC/3, 4, 1, 1'b0);
    phase_trim = 8'hf3;
    do_reset();
    run(5*DEC, 4, 2, 1'b0);

    repeat (3) tick(1'b0, 1'b0, 1'b0);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule